// File: doc/BRIEF.md
# Reset Supervisor Timing Controller

This block drives an active-low processor reset from two fault sources. The first is a supply-good level from an external voltage comparator. The second is an active-low manual-reset pushbutton. While either fault is present, the reset output is held low. Once both faults have cleared, the output stays low for a selectable timeout and then goes high. Any fault that appears during that wait throws away the time already counted, so the output goes high only after one full quiet timeout.

The timeout is counted in pulses of a slow tick enable, such as a 0.1 ms strobe from a prescaler. A 2-bit select picks one of four terminal counts, and these counts are parameters. The default counts give roughly 1.6 ms, 26 ms, 200 ms and 1.57 s at a 0.1 ms tick. The pushbutton needs no separate debouncer: every bounce is a new fault and restarts the wait. Both fault inputs pass through a two-flop synchronizer first. The select is captured only while reset is asserted and the count is still zero.

Top module: `rst_supervisor`

## Requirements
- R1: While `porRst` is high at a clock edge, `cpuRstN` is 0 after that edge. The timeout count is cleared and the captured select becomes 0.
- R2: A low level on `supplyOk` drives `cpuRstN` low. The output falls after the third rising edge at which the low level is sampled, because the synchronizer adds two cycles and the output register adds one.
- R3: A low level on `manRstN` forces `cpuRstN` low with the same three-edge latency as R2.
- R4: When both faults clear with `tickEn` held high, `cpuRstN` stays low for exactly TERMsel+2 cycles, counted from the first edge that sees the recovered input. It then goes high. With a sparser `tickEn`, it goes high one cycle after the TERMsel-th counted tick.
- R5: A supply fault that arrives while a reset pulse is already counting clears the count. After the fault clears, a full TERMsel+2 cycle wait follows.
- R6: Bounces on `manRstN` each restart the wait. The output goes high only TERMsel+2 cycles after the last release, and it stays low during the bouncing.
- R7: While `supplyOk` stays low, `cpuRstN` stays low, no matter how many ticks arrive.
- R8: `tmoSel` is captured only in a cycle where reset is asserted and the count is zero. A change of `tmoSel` in the middle of a pulse does not change that pulse's length.
- R9: Once `cpuRstN` is high, it stays high until a synchronized fault appears.
- R10: The select encoding is 0 for TERM0, 1 for TERM1, 2 for TERM2 and 3 for TERM3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| porRst | input | 1 | Synchronous power-on reset, active high |
| supplyOk | input | 1 | Supply-above-threshold level from the comparator |
| manRstN | input | 1 | Manual reset pushbutton, active low |
| tickEn | input | 1 | One-cycle timebase strobe that advances the timeout |
| tmoSel | input | 2 | Timeout select (R10 encoding) |
| cpuRstN | output | 1 | Processor reset, active low, registered |

## Verification
The bench measures the exact length of the low pulse for each of the four selects. An off-by-one in the terminal compare, or a wrong mapping from select to count, shows up as a wrong cycle count. It cuts a running pulse short with a supply dip and with a bouncing button. A design that pauses the count instead of clearing it would release early. It changes the select in the middle of a pulse, which a design that samples the select continuously would turn into a shortened reset. It also checks the three-edge fault latency, and that the output stays low through a long brownout while ticks keep arriving.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

  // Strobes from control to the timeout datapath
  typedef struct packed {
    logic clearCnt;   // drop the count to zero
    logic countEn;    // advance the count by one tick
    logic loadSel;    // capture the timeout select
  } tmrCmd_t;

endpackage

// File: rtl/rst_sup_sync.sv
module rst_sup_sync #(
  parameter int unsigned         W       = 2,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk,
  input  logic         porRst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk) begin
      if (porRst) begin
        stage1 <= RST_VAL[i];
        stage2 <= RST_VAL[i];
      end else begin
        stage1 <= din[i];
        stage2 <= stage1;
      end
    end
    assign dout[i] = stage2;
  end

endmodule

// File: rtl/rst_sup_timer.sv
module rst_sup_timer
  import rst_sup_pkg::*;
#(
  parameter int unsigned TERM0 = 16,
  parameter int unsigned TERM1 = 260,
  parameter int unsigned TERM2 = 2000,
  parameter int unsigned TERM3 = 15700
) (
  input  logic       clk,
  input  logic       porRst,
  input  tmrCmd_t    cmd,
  input  logic [1:0] tmoSel,
  output logic       atTerm,
  output logic       cntZero,
  output logic [1:0] selLatched
);

  localparam int unsigned MAX01 = (TERM0 > TERM1) ? TERM0 : TERM1;
  localparam int unsigned MAX23 = (TERM2 > TERM3) ? TERM2 : TERM3;
  localparam int unsigned MAXT  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned CNT_W = $clog2(MAXT + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] termSel;

  always_comb begin
    case (selLatched)
      2'd0:    termSel = CNT_W'(TERM0);
      2'd1:    termSel = CNT_W'(TERM1);
      2'd2:    termSel = CNT_W'(TERM2);
      default: termSel = CNT_W'(TERM3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (porRst || cmd.clearCnt) cnt <= '0;
    else if (cmd.countEn)       cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (porRst)           selLatched <= 2'd0;
    else if (cmd.loadSel) selLatched <= tmoSel;
  end

  assign atTerm  = (cnt == termSel);
  assign cntZero = (cnt == '0);

endmodule

// File: rtl/rst_sup_ctrl.sv
module rst_sup_ctrl
  import rst_sup_pkg::*;
(
  input  logic    clk,
  input  logic    porRst,
  input  logic    faultS,
  input  logic    tickEn,
  input  logic    atTerm,
  input  logic    cntZero,
  output tmrCmd_t cmd,
  output logic    rstAsserted
);

  always_comb begin
    cmd.clearCnt = faultS;
    cmd.countEn  = rstAsserted && !faultS && tickEn && !atTerm;
    cmd.loadSel  = rstAsserted && cntZero;
  end

  always_ff @(posedge clk) begin
    if (porRst || faultS)          rstAsserted <= 1'b1;
    else if (rstAsserted && atTerm) rstAsserted <= 1'b0;
  end

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rst_sup_pkg::*;
#(
  parameter int unsigned TERM0 = 16,
  parameter int unsigned TERM1 = 260,
  parameter int unsigned TERM2 = 2000,
  parameter int unsigned TERM3 = 15700
) (
  input  logic       clk,
  input  logic       porRst,
  input  logic       supplyOk,
  input  logic       manRstN,
  input  logic       tickEn,
  input  logic [1:0] tmoSel,
  output logic       cpuRstN
);

  logic [1:0] syncQ;
  logic       faultS;
  logic       atTerm;
  logic       cntZero;
  logic [1:0] selLatched;
  logic       rstAsserted;
  tmrCmd_t    cmd;

  rst_sup_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .porRst(porRst), .din({supplyOk, manRstN}), .dout(syncQ)
  );

  assign faultS = !syncQ[1] || !syncQ[0];

  rst_sup_ctrl u_ctrl (
    .clk(clk), .porRst(porRst), .faultS(faultS), .tickEn(tickEn),
    .atTerm(atTerm), .cntZero(cntZero), .cmd(cmd), .rstAsserted(rstAsserted)
  );

  rst_sup_timer #(.TERM0(TERM0), .TERM1(TERM1), .TERM2(TERM2), .TERM3(TERM3)) u_timer (
    .clk(clk), .porRst(porRst), .cmd(cmd), .tmoSel(tmoSel),
    .atTerm(atTerm), .cntZero(cntZero), .selLatched(selLatched)
  );

  assign cpuRstN = !rstAsserted;

endmodule

// File: rtl/rst_sup_checker.sv
module rst_sup_checker #(
  parameter int unsigned TERM0 = 16,
  parameter int unsigned TERM1 = 260,
  parameter int unsigned TERM2 = 2000,
  parameter int unsigned TERM3 = 15700
) (
  input logic       clk,
  input logic       porRst,
  input logic       tickEn,
  input logic       faultS,
  input logic       cpuRstN,
  input logic [1:0] selLatched,
  input logic       cntZero
);

  localparam int unsigned MIN01 = (TERM0 < TERM1) ? TERM0 : TERM1;
  localparam int unsigned MIN23 = (TERM2 < TERM3) ? TERM2 : TERM3;
  localparam int unsigned MINT  = (MIN01 < MIN23) ? MIN01 : MIN23;

  // Ticks seen while asserted since the last fault (saturating)
  int unsigned quietTicks;
  always_ff @(posedge clk) begin
    if (porRst || faultS)                quietTicks <= 0;
    else if (tickEn && !cpuRstN && quietTicks != 32'hFFFF_FFFF)
      quietTicks <= quietTicks + 1;
  end

  assert_por_low_R1: assert property (@(posedge clk) porRst |=> !cpuRstN);

  assert_fault_forces_R2: assert property (@(posedge clk) disable iff (porRst)
    faultS |=> !cpuRstN);

  assert_full_timeout_R4: assert property (@(posedge clk) disable iff (porRst)
    $rose(cpuRstN) |-> quietTicks >= MINT);

  assert_sel_frozen_R8: assert property (@(posedge clk) disable iff (porRst)
    (!cntZero || cpuRstN) |=> $stable(selLatched));

  assert_stays_released_R9: assert property (@(posedge clk) disable iff (porRst)
    (cpuRstN && !faultS) |=> cpuRstN);

endmodule

bind rst_supervisor rst_sup_checker #(
  .TERM0(TERM0), .TERM1(TERM1), .TERM2(TERM2), .TERM3(TERM3)
) u_chk (
  .clk(clk), .porRst(porRst), .tickEn(tickEn), .faultS(faultS),
  .cpuRstN(cpuRstN), .selLatched(selLatched), .cntZero(cntZero)
);

// File: tb/tb_rst_supervisor.sv
`timescale 1ns/1ps
module tb_rst_supervisor;

  localparam int T0 = 3, T1 = 6, T2 = 10, T3 = 15;
  localparam int TT[4] = '{T0, T1, T2, T3};

  logic       clk = 0;
  logic       porRst = 1;
  logic       supplyOk = 0;
  logic       manRstN = 1;
  logic       tickEn = 0;
  logic [1:0] tmoSel = 0;
  logic       cpuRstN;

  int checks = 0;
  int fails = 0;
  int tickMode = 0;   // 0: every cycle, 1: random
  bit started = 0;

  always #4 clk = ~clk;

  rst_supervisor #(.TERM0(T0), .TERM1(T1), .TERM2(T2), .TERM3(T3)) dut (
    .clk(clk), .porRst(porRst), .supplyOk(supplyOk), .manRstN(manRstN),
    .tickEn(tickEn), .tmoSel(tmoSel), .cpuRstN(cpuRstN)
  );

  // Behavioural reference: two-deep input delay queue plus integer timer
  logic [1:0] mq[$];
  int  mCnt = 0;
  int  mSel = 0;
  bit  mRst = 1;

  always @(posedge clk) begin
    logic [1:0] oldest;
    bit flt;
    int nSel;
    if (porRst) begin
      mq = '{2'b01, 2'b01};
      mRst = 1; mCnt = 0; mSel = 0;
      started = 1;
    end else begin
      oldest = mq[0];
      flt = !oldest[1] || !oldest[0];
      nSel = (mRst && mCnt == 0) ? int'(tmoSel) : mSel;
      if (flt) begin
        mCnt = 0; mRst = 1;
      end else if (mRst) begin
        if (mCnt == TT[mSel]) mRst = 0;
        else if (tickEn) mCnt++;
      end
      mSel = nSel;
      void'(mq.pop_front());
      mq.push_back({supplyOk, manRstN});
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock (R2 R3 R4 R5 R6 R9)
  always @(negedge clk) begin
    if (started)
      check(cpuRstN === !mRst, "R2/R3/R4/R5/R6/R9 model", int'(cpuRstN), int'(!mRst));
  end

  // Tick generator
  always @(negedge clk) begin
    if (tickMode == 0) tickEn = 1;
    else tickEn = ($urandom_range(0, 3) == 0);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measureLow(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (cpuRstN === 1'b0 && n < 2000) n++;
      else break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int hi;
    step(1);
    step(2);
    check(cpuRstN === 1'b0, "R1 low during por", int'(cpuRstN), 0);
    supplyOk = 1; manRstN = 1;
    porRst = 0;
    step(1);
    check(cpuRstN === 1'b0, "R1 low after por", int'(cpuRstN), 0);
    measureLow(n);
    step(5);

    // R4 / R10: pulse length per select
    for (int s = 0; s < 4; s++) begin
      supplyOk = 0; tmoSel = 2'(s);
      step(5);
      supplyOk = 1;
      measureLow(n);
      check(n == TT[s] + 2, $sformatf("R4 R10 length sel%0d", s), n, TT[s] + 2);
      step(4);
    end

    // R8: select change mid-pulse
    supplyOk = 0; tmoSel = 2'd3;
    step(5);
    supplyOk = 1;
    step(5);
    tmoSel = 2'd0;
    measureLow(n);
    check(n + 5 == T3 + 2, "R8 sel change ignored", n + 5, T3 + 2);
    step(4);

    // R5: supply dip during pulse
    supplyOk = 0; tmoSel = 2'd1;
    step(5);
    supplyOk = 1;
    step(4);
    check(cpuRstN === 1'b0, "R5 still low before dip", int'(cpuRstN), 0);
    supplyOk = 0;
    step(5);
    check(cpuRstN === 1'b0, "R5 low during dip", int'(cpuRstN), 0);
    supplyOk = 1;
    measureLow(n);
    check(n == T1 + 2, "R5 full restart", n, T1 + 2);
    step(4);

    // R3: manual reset latency
    manRstN = 0; tmoSel = 2'd2;
    step(1);
    check(cpuRstN === 1'b1, "R3 latency edge1", int'(cpuRstN), 1);
    step(1);
    check(cpuRstN === 1'b1, "R3 latency edge2", int'(cpuRstN), 1);
    step(1);
    check(cpuRstN === 1'b0, "R3 low at edge3", int'(cpuRstN), 0);
    manRstN = 1;
    measureLow(n);
    check(n == T2 + 2, "R3 release length", n, T2 + 2);
    step(4);

    // R6: bouncing button
    manRstN = 0; step(2);
    manRstN = 1; step(4);
    manRstN = 0; step(1);
    manRstN = 1; step(3);
    manRstN = 0; step(3);
    check(cpuRstN === 1'b0, "R6 low while bouncing", int'(cpuRstN), 0);
    manRstN = 1;
    measureLow(n);
    check(n == T2 + 2, "R6 length after last bounce", n, T2 + 2);

    // R9: stays released
    hi = 0;
    for (int i = 0; i < 60; i++) begin
      step(1);
      if (cpuRstN === 1'b1) hi++;
    end
    check(hi == 60, "R9 stays high", hi, 60);

    // R7: long brownout
    supplyOk = 0;
    step(3);
    hi = 0;
    for (int i = 0; i < 300; i++) begin
      step(1);
      if (cpuRstN !== 1'b0) hi++;
    end
    check(hi == 0, "R7 high samples during brownout", hi, 0);
    supplyOk = 1;
    measureLow(n);

    // Random phase with sparse ticks, model compare each clock
    tickMode = 1;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 39) == 0) supplyOk = ~supplyOk;
      if ($urandom_range(0, 29) == 0) manRstN = ~manRstN;
      if ($urandom_range(0, 9) == 0) tmoSel = 2'($urandom_range(0, 3));
      if (i > 5000) begin supplyOk = 1; manRstN = 1; end
    end

    // R1: reset mid-operation
    porRst = 1;
    step(1);
    check(cpuRstN === 1'b0, "R1 low on late por", int'(cpuRstN), 0);
    porRst = 0;
    step(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule